// File: doc/BRIEF.md
# Floating-Point Status Flag Mapper

This block sits beside a floating-point unit and turns the fine-grained status bits of each completed operation into the sticky flags of a floating-point control/status register. The unit reports thirteen individual causes per operation, with a valid strobe. The mapper folds them into eight flags. All nine invalid-operation causes collapse into one generic invalid flag. The two NaN causes also set their own flags. Only the two infinity-arithmetic causes set the infinity flag.

The register holds a global exception-enable bit beside the flags. While that bit is clear, completions leave the register untouched and never trap. While it is set, each completion ORs its flags into the register. The completion raises a one-cycle exception request if any flag bit is set after the update. The request carries the previous-PC value given with the operation as the faulting address. Software loads the whole register through a separate write port. A software write is the only way to clear flags.

Top module: `fpx_flag_mapper`

## Requirements
- R1: After reset, `csr_q` is 0, `exc_req` is 0 and `exc_pc` is 0.
- R2: While `csr_q[0]` (exception enable) is 0, a strobe on `sts_vld` changes no bit of `csr_q` and raises no `exc_req`, whatever `sts_cause` holds.
- R3: With enable set, any of the invalid causes sets the invalid flag `csr_q[1]`. The invalid causes are `sts_cause` bits 0 (signalling NaN), 1 (quiet NaN), 2 (inf minus inf), 3 (inf divided by inf), 4 (zero divided by zero), 5 (inf times zero), 6 (invalid conversion), 7 (invalid compare) and 8 (negative square root).
- R4: With enable set, cause bit 0 sets the signalling-NaN flag `csr_q[2]`, and cause bit 1 sets the quiet-NaN flag `csr_q[3]`.
- R5: The infinity flag `csr_q[4]` is set only by cause bits 2 and 3, and never without the invalid flag.
- R6: With enable set, cause bit 9 (overflow) sets `csr_q[5]`, and cause bit 10 (underflow) sets `csr_q[6]`.
- R7: With enable set, cause bit 11 (divide by zero) sets `csr_q[7]`, and cause bit 12 (inexact) sets `csr_q[8]`.
- R8: A strobe with enable set raises `exc_req` on the cycle after the strobe when any of `csr_q[8:1]` is set after the update. This includes flags that were already sticky. `exc_pc` then holds the `prev_pc` sampled with the strobe.
- R9: Flags are sticky. Only `sw_wr` can clear them, and it loads `sw_wdata` into all of `csr_q`. If `sw_wr` and `sts_vld` fall in the same cycle, the write wins: that completion updates no flag and raises no request.
- R10: `exc_req` lasts one cycle per strobe and is 0 in any cycle that follows a cycle without `sts_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sts_vld | input | 1 | A floating-point operation completed this cycle |
| sts_cause | input | 13 | Per-operation cause bits, positions as in R3 to R7 |
| prev_pc | input | PC_W | PC of the completing operation |
| sw_wr | input | 1 | Software write strobe for the control register |
| sw_wdata | input | 9 | Value loaded into the control register on `sw_wr` |
| csr_q | output | 9 | Control register: bit 0 enable, bits 8:1 sticky flags |
| exc_req | output | 1 | One-cycle floating-point exception request |
| exc_pc | output | PC_W | Faulting PC for the current request |

## Verification
The flag register is the only state in the block, and every bit of it is visible on `csr_q`. A wrong fold, a lost sticky bit or a missed enable gate therefore shows on the port one cycle after the strobe that caused it. A wrong request decision shows on `exc_req` in the same cycle. A stale or early PC capture appears on `exc_pc` together with the request it belongs to. Each cause is driven alone against a register that holds only the enable bit, so that a bit landing in the wrong flag cannot hide behind a correct one.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int CAUSE_W = 13;
  localparam int FLAG_W  = 8;
  localparam int CSR_W   = FLAG_W + 1;

  // cause positions in the status vector
  localparam int C_SNAN  = 0;
  localparam int C_QNAN  = 1;
  localparam int C_ISI   = 2;
  localparam int C_IDI   = 3;
  localparam int C_ZDZ   = 4;
  localparam int C_IMZ   = 5;
  localparam int C_CVI   = 6;
  localparam int C_CMP   = 7;
  localparam int C_SQRT  = 8;
  localparam int C_OVF   = 9;
  localparam int C_UNF   = 10;
  localparam int C_DIV0  = 11;
  localparam int C_INEX  = 12;

  // flag positions inside the flag field (register bit = index + 1)
  localparam int F_INV   = 0;
  localparam int F_SNAN  = 1;
  localparam int F_QNAN  = 2;
  localparam int F_INF   = 3;
  localparam int F_OVF   = 4;
  localparam int F_UNF   = 5;
  localparam int F_DZ    = 6;
  localparam int F_INEX  = 7;

  typedef logic [CAUSE_W-1:0] cause_t;
  typedef logic [FLAG_W-1:0]  flag_t;
  typedef logic [CSR_W-1:0]   csr_t;

  function automatic flag_t fold_causes(input cause_t c);
    flag_t f;
    f         = '0;
    f[F_INV]  = |c[C_SQRT:C_SNAN];
    f[F_SNAN] = c[C_SNAN];
    f[F_QNAN] = c[C_QNAN];
    f[F_INF]  = c[C_ISI] | c[C_IDI];
    f[F_OVF]  = c[C_OVF];
    f[F_UNF]  = c[C_UNF];
    f[F_DZ]   = c[C_DIV0];
    f[F_INEX] = c[C_INEX];
    return f;
  endfunction
endpackage

// File: rtl/fpx_cause_fold.sv
module fpx_cause_fold
  import fpx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cause_t cause,
  output flag_t  set_mask
);
  assign set_mask = fold_causes(cause);

  // R5: infinity flag never appears without the invalid flag
  assert_inf_needs_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_mask[F_INF] |-> set_mask[F_INV]);
endmodule

// File: rtl/fpx_csr_reg.sv
module fpx_csr_reg
  import fpx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sts_vld,
  input  flag_t set_mask,
  input  logic  sw_wr,
  input  csr_t  sw_wdata,
  output csr_t  csr_q,
  output logic  raise_evt
);
  logic  update_evt;
  csr_t  csr_next;

  assign update_evt = sts_vld && csr_q[0] && !sw_wr;

  always_comb begin
    csr_next = csr_q;
    if (sw_wr)
      csr_next = sw_wdata;
    else if (update_evt)
      csr_next = csr_q | {set_mask, 1'b0};
  end

  assign raise_evt = update_evt && (csr_next[CSR_W-1:1] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csr_q <= '0;
    else        csr_q <= csr_next;
  end

  // R2: a strobe with enable clear leaves the register untouched
  assert_gate_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_vld && !csr_q[0] && !sw_wr) |=> $stable(csr_q));

  // R9: without a software write no flag ever falls
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> (($past(csr_q[CSR_W-1:1]) & ~csr_q[CSR_W-1:1]) == '0));
endmodule

// File: rtl/fpx_exc_gen.sv
module fpx_exc_gen #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raise_evt,
  input  logic [PC_W-1:0] prev_pc,
  output logic            exc_req,
  output logic [PC_W-1:0] exc_pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req <= 1'b0;
      exc_pc  <= '0;
    end else begin
      exc_req <= raise_evt;
      if (raise_evt) exc_pc <= prev_pc;
    end
  end
endmodule

// File: rtl/fpx_flag_mapper.sv
module fpx_flag_mapper
  import fpx_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sts_vld,
  input  logic [CAUSE_W-1:0]  sts_cause,
  input  logic [PC_W-1:0]     prev_pc,
  input  logic                sw_wr,
  input  logic [CSR_W-1:0]    sw_wdata,
  output logic [CSR_W-1:0]    csr_q,
  output logic                exc_req,
  output logic [PC_W-1:0]     exc_pc
);
  flag_t set_mask;
  logic  raise_evt;

  fpx_cause_fold u_fold (
    .clk      (clk),
    .rst_n    (rst_n),
    .cause    (sts_cause),
    .set_mask (set_mask)
  );

  fpx_csr_reg u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .sts_vld   (sts_vld),
    .set_mask  (set_mask),
    .sw_wr     (sw_wr),
    .sw_wdata  (sw_wdata),
    .csr_q     (csr_q),
    .raise_evt (raise_evt)
  );

  fpx_exc_gen #(.PC_W(PC_W)) u_exc (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise_evt (raise_evt),
    .prev_pc   (prev_pc),
    .exc_req   (exc_req),
    .exc_pc    (exc_pc)
  );

  // R8: a request always has a flag standing behind it
  assert_exc_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (csr_q[CSR_W-1:1] != '0));

  // R8: the request carries the PC offered with its strobe
  assert_exc_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (exc_pc == $past(prev_pc)));

  // R10: no strobe, no request in the next cycle
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_vld |=> !exc_req);

  // R2: disabled register never traps
  assert_gate_noexc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_vld && !csr_q[0]) |=> !exc_req);
endmodule

// File: tb/fpx_flag_mapper_tb.sv
module fpx_flag_mapper_tb;
  localparam int CLK_P = 10;
  localparam int PC_W  = 32;
  localparam int NV    = 19;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sts_vld = 1'b0;
  logic [12:0]     sts_cause = '0;
  logic [PC_W-1:0] prev_pc = '0;
  logic            sw_wr = 1'b0;
  logic [8:0]      sw_wdata = '0;
  logic [8:0]      csr_q;
  logic            exc_req;
  logic [PC_W-1:0] exc_pc;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  fpx_flag_mapper #(.PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sts_vld(sts_vld), .sts_cause(sts_cause),
    .prev_pc(prev_pc), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .csr_q(csr_q), .exc_req(exc_req), .exc_pc(exc_pc)
  );

  // {requirement number, preload, cause, expected register, expected request}
  localparam logic [35:0] VEC [NV] = '{
    {4'd4,  9'h001, 13'h0001, 9'h007, 1'b1}, // R4 R3 signalling NaN
    {4'd4,  9'h001, 13'h0002, 9'h00B, 1'b1}, // R4 R3 quiet NaN
    {4'd5,  9'h001, 13'h0004, 9'h013, 1'b1}, // R5 inf-inf
    {4'd5,  9'h001, 13'h0008, 9'h013, 1'b1}, // R5 inf/inf
    {4'd3,  9'h001, 13'h0010, 9'h003, 1'b1}, // R3 0/0
    {4'd3,  9'h001, 13'h0020, 9'h003, 1'b1}, // R3 inf*0
    {4'd3,  9'h001, 13'h0040, 9'h003, 1'b1}, // R3 conversion
    {4'd3,  9'h001, 13'h0080, 9'h003, 1'b1}, // R3 compare
    {4'd3,  9'h001, 13'h0100, 9'h003, 1'b1}, // R3 sqrt
    {4'd6,  9'h001, 13'h0200, 9'h021, 1'b1}, // R6 overflow
    {4'd6,  9'h001, 13'h0400, 9'h041, 1'b1}, // R6 underflow
    {4'd7,  9'h001, 13'h0800, 9'h081, 1'b1}, // R7 divide by zero
    {4'd7,  9'h001, 13'h1000, 9'h101, 1'b1}, // R7 inexact
    {4'd2,  9'h000, 13'h1FFF, 9'h000, 1'b0}, // R2 disabled, empty
    {4'd2,  9'h1FE, 13'h1FFF, 9'h1FE, 1'b0}, // R2 disabled, flags held
    {4'd8,  9'h021, 13'h0000, 9'h021, 1'b1}, // R8 sticky flag re-raises
    {4'd8,  9'h001, 13'h0000, 9'h001, 1'b0}, // R8 no flag, no request
    {4'd9,  9'h041, 13'h0200, 9'h061, 1'b1}, // R9 sticky accumulation
    {4'd3,  9'h001, 13'h1FFF, 9'h1FF, 1'b1}  // R3 all causes
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic sw_load(input logic [8:0] v);
    @(negedge clk); sw_wr = 1'b1; sw_wdata = v;
    @(negedge clk); sw_wr = 1'b0;
  endtask

  initial begin
    #(CLK_P * 5000);
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    string rq;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(csr_q == 9'h000, "R1", "csr_q", 32'(csr_q), 32'h0);
    check(exc_req == 1'b0, "R1", "exc_req", 32'(exc_req), 32'h0);
    check(exc_pc == '0, "R1", "exc_pc", exc_pc, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] pc;
      pc = 32'h1000 + 32'(i) * 32'h40;
      rq = $sformatf("R%0d", VEC[i][35:32]);
      sw_load(VEC[i][31:23]);
      sts_vld = 1'b1; sts_cause = VEC[i][22:10]; prev_pc = pc;
      @(negedge clk);
      sts_vld = 1'b0; sts_cause = '0; prev_pc = 32'hDEAD_0000;
      check(csr_q == VEC[i][9:1], rq, $sformatf("csr_q vec %0d", i),
            32'(csr_q), 32'(VEC[i][9:1]));
      check(exc_req == VEC[i][0], rq, $sformatf("exc_req vec %0d", i),
            32'(exc_req), 32'(VEC[i][0]));
      if (VEC[i][0])
        check(exc_pc == pc, "R8", $sformatf("exc_pc vec %0d", i), exc_pc, pc);
      @(negedge clk);
      check(exc_req == 1'b0, "R10", $sformatf("pulse end vec %0d", i),
            32'(exc_req), 32'h0);
    end

    // R9: software write wins over a same-cycle completion
    sw_load(9'h001);
    sw_wr = 1'b1; sw_wdata = 9'h101; sts_vld = 1'b1; sts_cause = 13'h0200;
    prev_pc = 32'h2000;
    @(negedge clk);
    sw_wr = 1'b0; sts_vld = 1'b0; sts_cause = '0;
    check(csr_q == 9'h101, "R9", "write priority csr_q", 32'(csr_q), 32'h101);
    check(exc_req == 1'b0, "R9", "write priority exc_req", 32'(exc_req), 32'h0);

    // R9: software write clears sticky flags
    sw_load(9'h001);
    check(csr_q == 9'h001, "R9", "clear by write", 32'(csr_q), 32'h001);

    // R10 R8: back-to-back strobes, PC follows each
    @(negedge clk);
    sts_vld = 1'b1; sts_cause = 13'h1000; prev_pc = 32'h3000;
    @(negedge clk);
    check(exc_req == 1'b1, "R10", "first of pair", 32'(exc_req), 32'h1);
    check(exc_pc == 32'h3000, "R8", "first pc", exc_pc, 32'h3000);
    sts_cause = 13'h0000; prev_pc = 32'h3004;
    @(negedge clk);
    sts_vld = 1'b0;
    check(exc_req == 1'b1, "R10", "second of pair", 32'(exc_req), 32'h1);
    check(exc_pc == 32'h3004, "R8", "second pc", exc_pc, 32'h3004);
    @(negedge clk);
    check(exc_req == 1'b0, "R10", "pair end", 32'(exc_req), 32'h0);
    check(exc_pc == 32'h3004, "R8", "pc held", exc_pc, 32'h3004);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule